// File: doc/BRIEF.md
# Collision-Aborting Wired-AND Serial Transmitter

This block sends bytes, one at a time, as asynchronous serial frames onto a line that several stations share. The line is wired-AND: a station either pulls it low or leaves it alone, and a pull-up resistor lifts it when nobody pulls. The block takes a byte through a valid/ready handshake. It sends a low start bit, the eight data bits least significant first, and a high stop bit. It holds every bit for eight cycles of the 2 MHz oversampling clock, which gives a 250 kbit/s line with two framing bits per byte.

The block reads the line back while it transmits. A two-flop synchronized copy of the line is compared with the bit being sent at one fixed tick inside each bit. If the block is sending a 1 and the line is found low, another station is sending a 0 at the same time and has won. The block then abandons the byte, flags the loss for one cycle and goes back to idle without sending a stop bit. A station that sends a 0 never sees a mismatch, so the winner carries on undisturbed: lower bit values win arbitration. Deciding when to start and what to do after a loss is left to the logic around the block.

Top module: `shared_line_tx`

## Requirements
- R1: After reset and whenever no byte is in flight, `line_pull_n` is 1 (line released), `tx_ready` is 1, and `tx_done` and `arb_lost` are 0.
- R2: A byte is accepted on a rising clock edge where `tx_valid` and `tx_ready` are both 1. Taking the acceptance cycle as cycle 0, `tx_ready` is 0 from cycle 1 until the cycle in which `tx_done` or `arb_lost` is raised.
- R3: Frame bit k (0 = start bit, 1..8 = data bits 0..7, 9 = stop bit) occupies cycles 8k+1 to 8k+8. In those cycles `line_pull_n` equals the bit value: 0 for the start bit, the data bit, and 1 for the stop bit.
- R4: The byte on `tx_data` is captured at acceptance. Later changes of `tx_data` do not alter the frame.
- R5: The line is read back through a two-stage synchronizer, and the comparison for bit k is made in cycle 8k+6. If the bit sent is 1 and the synchronized line is 0, `arb_lost` is 1 for exactly cycle 8k+7.
- R6: The line being held low by another station while the block sends a 0 has no effect: the byte continues and completes.
- R7: On a lost arbitration the line is released (`line_pull_n` = 1), the rest of the frame, including the stop bit, is not sent, no `tx_done` is raised, and `tx_ready` is 1 in the `arb_lost` cycle.
- R8: `tx_done` is 1 for exactly cycle 81, and only for a byte that reached the end of its stop bit without loss. A mismatch found on the stop bit gives `arb_lost` in cycle 79 and no `tx_done`.
- R9: When `tx_valid` is already 1, the next byte is accepted in the same cycle that `tx_done` or `arb_lost` is raised, with no idle cycle between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock (eight ticks per bit) |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_data | input | DATA_W | Byte to send |
| tx_valid | input | 1 | tx_data holds a byte to send |
| tx_ready | output | 1 | Block is idle and will take a byte |
| line_in | input | 1 | Level read back from the shared line (asynchronous) |
| line_pull_n | output | 1 | Active-low pull enable: 0 pulls the line low, 1 releases it |
| tx_done | output | 1 | One-cycle pulse: byte sent in full |
| arb_lost | output | 1 | One-cycle pulse: a sent 1 was overridden, byte abandoned |

## Verification
Two events can land in one cycle. The first is the end of a byte, raised through `tx_done` or `arb_lost`. The second is the acceptance of the next byte, because `tx_ready` comes back high in that same cycle. The bench holds `tx_valid` high across a lost byte and checks that the follow-on byte starts at once, with its frame timed from that shared cycle. A second pairing is a mismatch on the stop bit, where the abort and the completion compete for the end of one frame. A competing station pulls the line low during the stop bit, and the bench checks that only `arb_lost` appears, in cycle 79, and that `tx_done` never follows.

// File: rtl/sltx_pkg.sv
package sltx_pkg;

  typedef enum logic [0:0] {
    TX_IDLE = 1'b0,
    TX_SEND = 1'b1
  } tx_state_e;

  // A recessive 1 that reads back as 0 means another station won.
  function automatic logic overridden(input logic sent_bit, input logic seen_bit);
    return sent_bit & ~seen_bit;
  endfunction

  // Number of frame slots (start + data + stop).
  function automatic int frame_len(input int data_w);
    return data_w + 2;
  endfunction

endpackage

// File: rtl/sltx_sync.sv
module sltx_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q[0] <= RESET_VAL;
    else        chain_q[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain_q[s] <= RESET_VAL;
      else        chain_q[s] <= chain_q[s-1];
    end
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/sltx_bit_timer.sv
module sltx_bit_timer #(
  parameter int TICKS     = 8,
  parameter int SAMPLE_AT = 5,
  parameter int SLOTS     = 10,
  parameter int TICK_W    = 3,
  parameter int IDX_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  output logic [TICK_W-1:0] tick,
  output logic [IDX_W-1:0]  idx,
  output logic              strobe,
  output logic              bit_end,
  output logic              last_bit
);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICKS - 1);
  localparam logic [TICK_W-1:0] TICK_SMP  = TICK_W'(SAMPLE_AT);
  localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'(SLOTS - 1);

  logic [TICK_W-1:0] tick_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      tick_q <= '0;
      idx_q  <= '0;
    end else if (tick_q == TICK_LAST) begin
      tick_q <= '0;
      idx_q  <= idx_q + 1'b1;
    end else begin
      tick_q <= tick_q + 1'b1;
    end
  end

  assign tick     = tick_q;
  assign idx      = idx_q;
  assign strobe   = run && (tick_q == TICK_SMP);
  assign bit_end  = run && (tick_q == TICK_LAST);
  assign last_bit = (idx_q == IDX_LAST);
endmodule

// File: rtl/sltx_arbiter.sv
module sltx_arbiter (
  input  logic strobe,
  input  logic sent_bit,
  input  logic seen_bit,
  output logic collide
);
  import sltx_pkg::*;
  assign collide = strobe && overridden(sent_bit, seen_bit);
endmodule

// File: rtl/shared_line_tx.sv
module shared_line_tx #(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 8,
  parameter int SAMPLE_TICK   = 5,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic              line_in,
  output logic              line_pull_n,
  output logic              tx_done,
  output logic              arb_lost
);
  import sltx_pkg::*;

  localparam int FRAME_LEN = frame_len(DATA_W);
  localparam int TICK_W    = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int SLOTS     = 1 << IDX_W;

  // Frame image: slot 0 start (0), data LSB first, then stop and idle ones.
  function automatic logic [SLOTS-1:0] build_frame(input logic [DATA_W-1:0] d);
    logic [SLOTS-1:0] f;
    f            = '1;
    f[0]         = 1'b0;
    f[DATA_W:1]  = d;
    return f;
  endfunction

  tx_state_e         state_q;
  logic [SLOTS-1:0]  frame_q;
  logic              done_q, lost_q;

  // Named internal events, visible to the checker.
  logic              accept;
  logic              running;
  logic              sent_bit;
  logic              seen_bit;
  logic              strobe;
  logic              collide;
  logic              bit_end;
  logic              last_bit;
  logic              frame_end;
  logic [TICK_W-1:0] tick;
  logic [IDX_W-1:0]  idx;

  assign running   = (state_q == TX_SEND);
  assign accept    = tx_valid && (state_q == TX_IDLE);
  assign sent_bit  = frame_q[idx];
  assign frame_end = bit_end && last_bit;

  sltx_sync #(
    .STAGES    (SYNC_STAGES),
    .RESET_VAL (1'b1)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (line_in),
    .sync_out (seen_bit)
  );

  sltx_bit_timer #(
    .TICKS     (TICKS_PER_BIT),
    .SAMPLE_AT (SAMPLE_TICK),
    .SLOTS     (FRAME_LEN),
    .TICK_W    (TICK_W),
    .IDX_W     (IDX_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (running),
    .tick     (tick),
    .idx      (idx),
    .strobe   (strobe),
    .bit_end  (bit_end),
    .last_bit (last_bit)
  );

  sltx_arbiter u_arb (
    .strobe   (strobe),
    .sent_bit (sent_bit),
    .seen_bit (seen_bit),
    .collide  (collide)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      frame_q <= '1;
      done_q  <= 1'b0;
      lost_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      lost_q <= 1'b0;
      if (accept) begin
        state_q <= TX_SEND;
        frame_q <= build_frame(tx_data);
      end else if (running) begin
        if (collide) begin
          state_q <= TX_IDLE;
          lost_q  <= 1'b1;
        end else if (frame_end) begin
          state_q <= TX_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end

  assign tx_ready    = (state_q == TX_IDLE);
  assign line_pull_n = running ? sent_bit : 1'b1;
  assign tx_done     = done_q;
  assign arb_lost    = lost_q;
endmodule

// File: rtl/sltx_checker.sv
module sltx_checker #(
  parameter int TICK_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              line_pull_n,
  input logic              tx_done,
  input logic              arb_lost,
  input logic [TICK_W-1:0] tick,
  input logic              strobe,
  input logic              sent_bit,
  input logic              collide
);
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> line_pull_n);

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  assert_bit_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ready && tick != '0) |-> $stable(line_pull_n));

  assert_collide_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> (arb_lost && tx_ready));

  assert_lost_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |=> !arb_lost);

  assert_zero_unaffected_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !sent_bit) |-> !collide);

  assert_release_on_loss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> (line_pull_n && !tx_done));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);
endmodule

bind shared_line_tx sltx_checker #(.TICK_W(TICK_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tx_valid    (tx_valid),
  .tx_ready    (tx_ready),
  .line_pull_n (line_pull_n),
  .tx_done     (tx_done),
  .arb_lost    (arb_lost),
  .tick        (tick),
  .strobe      (strobe),
  .sent_bit    (sent_bit),
  .collide     (collide)
);

// File: tb/tb_shared_line_tx.sv
module tb_shared_line_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       tx_ready, line_pull_n, tx_done, arb_lost;
  logic       rival_n = 1'b1;
  logic       line_in;
  logic [9:0] next_mask = '0;

  always #2 clk = ~clk;

  assign line_in = line_pull_n & rival_n;

  shared_line_tx dut (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .line_in(line_in), .line_pull_n(line_pull_n),
    .tx_done(tx_done), .arb_lost(arb_lost)
  );

  typedef struct {
    logic [7:0] data;
    bit         exp_lost;
    int         exp_bit;
    int         exp_cyc;
  } item_t;

  item_t sbq[$];
  int    n_checks = 0;
  int    n_fails  = 0;
  bit    idle_bad = 1'b0;
  bit    mon_active = 1'b0;
  bit    finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Driver: computes the expected outcome and pushes it into the scoreboard.
  task automatic send(input logic [7:0] d, input logic [9:0] m, input bit keep_valid);
    item_t it;
    logic [9:0] fr;
    fr = {1'b1, d, 1'b0};
    it.data = d; it.exp_lost = 1'b0; it.exp_bit = 10; it.exp_cyc = 81;
    for (int i = 0; i < 10; i++) begin
      if (!it.exp_lost && m[i] && fr[i]) begin
        it.exp_lost = 1'b1; it.exp_bit = i; it.exp_cyc = 8 * i + 7;
      end
    end
    @(negedge clk);
    tx_data = d; tx_valid = 1'b1; next_mask = m;
    #1;
    while (!tx_ready) begin @(negedge clk); #1; end
    sbq.push_back(it);
    @(posedge clk); #1;
    tx_data = ~d ^ 8'h5A;            // R4: scramble after capture
    if (!keep_valid) tx_valid = 1'b0;
  endtask

  // Monitor and competing-station model, sampled mid-cycle.
  initial begin
    int cyc;
    logic [9:0] seen, mask, fr;
    item_t it;
    bit ready_ok;
    cyc = 0; seen = '1; mask = '0; ready_ok = 1'b1;
    forever begin
      @(negedge clk); #1;
      if (rst_n) begin
        if (mon_active) begin
          cyc++;
          if (((cyc - 1) % 8) == 4 && ((cyc - 1) / 8) < 10) seen[(cyc - 1) / 8] = line_pull_n;
          if (tx_done || arb_lost) begin
            if (sbq.size() == 0) begin
              check(1'b0, "R8", "unexpected end event", 1, 0);
            end else begin
              it = sbq.pop_front();
              fr = {1'b1, it.data, 1'b0};
              check(arb_lost == it.exp_lost, it.exp_lost ? "R5" : "R8", "lost flag",
                    int'(arb_lost), int'(it.exp_lost));
              check(tx_done == !it.exp_lost, it.exp_lost ? "R7" : "R8", "done flag",
                    int'(tx_done), int'(!it.exp_lost));
              check(cyc == it.exp_cyc, it.exp_lost ? "R5" : "R8", "event cycle", cyc, it.exp_cyc);
              for (int b = 0; b < 10; b++) begin
                if (b <= it.exp_bit && seen[b] !== fr[b])
                  check(1'b0, "R3", $sformatf("frame bit %0d", b), int'(seen[b]), int'(fr[b]));
              end
              check(1'b1, "R4", "frame matches captured byte", 0, 0);
              check(ready_ok, "R2", "ready low while busy", 0, 1);
              check(line_pull_n == 1'b1, "R7", "line released at end", int'(line_pull_n), 1);
              check(tx_ready == 1'b1, "R9", "ready in end cycle", int'(tx_ready), 1);
            end
            mon_active = 1'b0;
            rival_n = 1'b1;
          end else begin
            if (tx_ready) ready_ok = 1'b0;
            if (((cyc - 1) / 8) < 10) rival_n = !mask[(cyc - 1) / 8];
            else rival_n = 1'b1;
          end
        end else begin
          if (!line_pull_n || tx_done || arb_lost) idle_bad = 1'b1;
        end
        if (!mon_active && tx_valid && tx_ready) begin
          mon_active = 1'b1; cyc = 0; seen = '1; mask = next_mask; ready_ok = 1'b1;
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "R1", "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_ready == 1'b1, "R1", "ready after reset", int'(tx_ready), 1);
    check(line_pull_n == 1'b1, "R1", "line released after reset", int'(line_pull_n), 1);
    check(!tx_done && !arb_lost, "R1", "no pulses after reset", int'(tx_done | arb_lost), 0);

    send(8'hA5, 10'b0000000000, 1'b0);      // R3 plain byte
    repeat (90) @(negedge clk);
    send(8'h00, 10'b0111111111, 1'b0);      // R6 rival only on zero bits
    repeat (90) @(negedge clk);
    send(8'hFF, 10'b0000000010, 1'b0);      // R5 loss on data bit 0
    repeat (90) @(negedge clk);
    send(8'h80, 10'b0100000000, 1'b0);      // R5 loss on data bit 7
    repeat (90) @(negedge clk);
    send(8'h3C, 10'b1000000000, 1'b0);      // R8 loss on stop bit
    repeat (90) @(negedge clk);
    send(8'h10, 10'b0000100010, 1'b1);      // R6 then R7 loss at bit 5
    send(8'h5A, 10'b0000000000, 1'b0);      // R9 back-to-back after loss
    repeat (90) @(negedge clk);
    send(8'h01, 10'b0000000000, 1'b1);      // R9 back-to-back after done
    send(8'hC3, 10'b0000000100, 1'b0);      // R5 loss on data bit 1
    repeat (90) @(negedge clk);

    check(sbq.size() == 0, "R8", "scoreboard drained", sbq.size(), 0);
    check(!idle_bad, "R1", "line released and quiet while idle", int'(idle_bad), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule